// File: doc/BRIEF.md
# Vectored Interrupt Controller with Fast-Path Routing

The block gathers 32 level-sensitive interrupt sources and drives two request lines toward a processor. One is a normal interrupt line and the other is a fast one. Each source has an enable bit, a software-raise bit and a steering bit. The steering bit sends the source either to the fast line or to the normal line. The effective request of a source is its hardware input ORed with its software bit.

For normal-line sources the block keeps a table of 16 vector slots. Each slot binds one source number to a handler address. A lower slot index has higher priority. When software reads the current-vector register, it receives the handler address of the best eligible slot, and that slot's priority is marked as in service. Until software writes the same register, only strictly higher-priority slots can win a later read. A write to the current-vector register retires the most urgent level in service. Normal-line sources that no enabled slot claims are served through a default handler address, which ranks below every slot.

All state is reached over a simple register bus with a combinational read path. Writes are taken at the clock edge, and a read of the current-vector register changes state at the clock edge where the read strobe is high. A lock bit can restrict writes to privileged accesses.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A synchronous active-low reset clears the enable mask, software bits, steering bits, lock bit, every slot control, every slot address, the default address and all in-service levels. Both request outputs then stay low.
- R2: A write to offset 0x010 sets the enable bits given by the 1s in the data. A write to offset 0x014 clears the enable bits given by the 1s. A 0 bit in either write leaves that bit unchanged, and a read of 0x010 returns the enable mask.
- R3: A write to offset 0x018 sets software bits where the data has 1s, and a write to 0x01C clears them. A read of 0x018 returns the software bits. The effective request of a source is its input OR its software bit.
- R4: In the steering register at offset 0x00C, a 1 sends a source to the fast line and a 0 sends it to the normal line. irq_o is the OR over all sources of effective & enable & ~steer, and fiq_o is the OR of effective & enable & steer.
- R5: A read of offset 0x000 returns effective & enable & ~steer, and a read of 0x004 returns effective & enable & steer. Both reflect the inputs live in the same cycle.
- R6: Slot addresses are at 0x100 + 4*n and slot controls at 0x200 + 4*n, for n from 0 to 15. In a control word, bit 5 enables the slot and bits 4:0 name the source. A slot is eligible when it is enabled, its source is pending on the normal line, and its index is below every level in service. A read of 0x030 returns the address of the lowest-index eligible slot. Sources steered to the fast line never make a slot eligible.
- R7: When no slot is eligible, a read of 0x030 returns the default address held at 0x034. If, in addition, nothing is in service and some normal-line pending source is claimed by no enabled slot, that read puts the default level (ranked below all slots) in service.
- R8: A read of 0x030 that returns a slot address puts that slot's level in service. From then on, a slot of equal or lower priority cannot be returned, and such a read returns the default address and changes nothing.
- R9: Any accepted write to 0x030 removes the highest-priority level in service. If no level is in service, the write has no effect. Repeated writes unwind nested levels one at a time.
- R10: While bit 0 of the lock register at 0x020 is 1, writes with bus_priv low are ignored, including writes to 0x030 and to the lock register itself. Privileged writes still take effect.
- R11: Offsets 0xFE0, 0xFE4, 0xFE8 and 0xFEC return bytes 0 to 3 of the parameter ID_WORD (default 0x00537A21) in bits 7:0, with zeros above. Offset 0x300 and any unmapped offset read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_re | input | 1 | Read strobe; qualifies the side effect of reading 0x030 |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| src_req | input | NUM_SRC | Level-sensitive source requests |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The in-module properties assume that a read strobe for 0x030 and an accepted write to 0x030 never fall in the same cycle. They also assume that bus signals and source inputs hold defined values from the first clock edge. The bench drives every bus access from a task that asserts only one strobe at a time, with all inputs starting at zero. Source levels change only at falling edges, so the live status and request lines can be compared with the model half a cycle later.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
// Package: register offsets and slot control type of the vectored interrupt
// controller. Assumes a source number fits in five bits (at most 32 sources).
package vic_pkg;
    localparam logic [11:0] OFS_IRQ_STAT = 12'h000;
    localparam logic [11:0] OFS_FIQ_STAT = 12'h004;
    localparam logic [11:0] OFS_STEER    = 12'h00C;
    localparam logic [11:0] OFS_EN_SET   = 12'h010;
    localparam logic [11:0] OFS_EN_CLR   = 12'h014;
    localparam logic [11:0] OFS_SW_SET   = 12'h018;
    localparam logic [11:0] OFS_SW_CLR   = 12'h01C;
    localparam logic [11:0] OFS_LOCK     = 12'h020;
    localparam logic [11:0] OFS_CUR_VEC  = 12'h030;
    localparam logic [11:0] OFS_DEF_VEC  = 12'h034;
    localparam logic [3:0]  PAGE_VEC     = 4'h1;
    localparam logic [3:0]  PAGE_CTL     = 4'h2;
    localparam logic [7:0]  ID_ROW       = 8'hFE;

    typedef struct packed {
        logic       en;
        logic [4:0] src;
    } slot_ctl_t;
endpackage

// File: rtl/vic_regs.sv
`timescale 1ns/1ps
// Module: vic_regs
// Holds the software-visible state (enable, software raise, steering, lock,
// slot table, default address), forms the masked pending vectors and the
// combinational read mux. Assumes NUM_SRC <= 32 and NUM_SLOT <= 64.
module vic_regs
    import vic_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 32,
    parameter int unsigned NUM_SLOT = 16,
    parameter int unsigned VEC_W    = 32,
    parameter logic [31:0] ID_WORD  = 32'h0053_7A21
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [11:0]         bus_addr,
    input  logic [31:0]         bus_wdata,
    input  logic                bus_we,
    input  logic                bus_priv,
    input  logic [NUM_SRC-1:0]  src_req,
    input  logic [VEC_W-1:0]    vec_rd_val,
    output logic [31:0]         bus_rdata,
    output logic                wr_acc,
    output logic [NUM_SRC-1:0]  irq_pend,
    output logic [NUM_SRC-1:0]  fiq_pend,
    output slot_ctl_t           slot_ctl [NUM_SLOT],
    output logic [VEC_W-1:0]    slot_vec [NUM_SLOT],
    output logic [VEC_W-1:0]    def_vec
);
    localparam int unsigned SLOT_W = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1;

    logic [NUM_SRC-1:0] en_q, soft_q, steer_q, wmask, eff_req;
    logic               lock_q;
    logic [SLOT_W-1:0]  slot_idx;
    logic               in_vec_win, in_ctl_win, in_id_row;

    assign wmask      = bus_wdata[NUM_SRC-1:0];
    assign wr_acc     = bus_we && (bus_priv || !lock_q);
    assign slot_idx   = bus_addr[SLOT_W+1:2];
    assign in_vec_win = (bus_addr[11:8] == PAGE_VEC) && (32'(bus_addr[7:2]) < NUM_SLOT)
                        && (bus_addr[1:0] == 2'b00);
    assign in_ctl_win = (bus_addr[11:8] == PAGE_CTL) && (32'(bus_addr[7:2]) < NUM_SLOT)
                        && (bus_addr[1:0] == 2'b00);
    assign in_id_row  = (bus_addr[11:4] == ID_ROW) && (bus_addr[1:0] == 2'b00);

    // effective request and its split onto the two request lines
    assign eff_req  = src_req | soft_q;
    assign irq_pend = eff_req & en_q & ~steer_q;
    assign fiq_pend = eff_req & en_q & steer_q;

    // global control registers: steering, enable, software raise, lock, default
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            soft_q  <= '0;
            steer_q <= '0;
            lock_q  <= 1'b0;
            def_vec <= '0;
        end else if (wr_acc) begin
            case (bus_addr)
                OFS_STEER:   steer_q <= wmask;
                OFS_EN_SET:  en_q    <= en_q | wmask;
                OFS_EN_CLR:  en_q    <= en_q & ~wmask;
                OFS_SW_SET:  soft_q  <= soft_q | wmask;
                OFS_SW_CLR:  soft_q  <= soft_q & ~wmask;
                OFS_LOCK:    lock_q  <= bus_wdata[0];
                OFS_DEF_VEC: def_vec <= bus_wdata[VEC_W-1:0];
                default: ;
            endcase
        end
    end

    // one address word and one control word per vector slot
    for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_vec[g] <= '0;
                slot_ctl[g] <= '0;
            end else if (wr_acc && (32'(slot_idx) == g)) begin
                if (in_vec_win) slot_vec[g] <= bus_wdata[VEC_W-1:0];
                if (in_ctl_win) slot_ctl[g] <= bus_wdata[5:0];
            end
        end
    end

    // combinational read mux over all mapped offsets
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_IRQ_STAT: bus_rdata[NUM_SRC-1:0] = irq_pend;
            OFS_FIQ_STAT: bus_rdata[NUM_SRC-1:0] = fiq_pend;
            OFS_STEER:    bus_rdata[NUM_SRC-1:0] = steer_q;
            OFS_EN_SET:   bus_rdata[NUM_SRC-1:0] = en_q;
            OFS_SW_SET:   bus_rdata[NUM_SRC-1:0] = soft_q;
            OFS_LOCK:     bus_rdata[0]           = lock_q;
            OFS_CUR_VEC:  bus_rdata[VEC_W-1:0]   = vec_rd_val;
            OFS_DEF_VEC:  bus_rdata[VEC_W-1:0]   = def_vec;
            default: begin
                if (in_vec_win)      bus_rdata[VEC_W-1:0] = slot_vec[slot_idx];
                else if (in_ctl_win) bus_rdata[5:0]       = slot_ctl[slot_idx];
                else if (in_id_row)  bus_rdata[7:0]       = ID_WORD[{bus_addr[3:2], 3'b000} +: 8];
            end
        endcase
    end

    AST_EN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && bus_addr == OFS_EN_CLR) |=> ((en_q & $past(wmask)) == '0)); // R2
    AST_SOFT_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && bus_addr == OFS_SW_SET) |=> ((soft_q & $past(wmask)) == $past(wmask))); // R3
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && lock_q && !bus_priv) |=> ($stable(en_q) && $stable(steer_q) && $stable(soft_q) && $stable(lock_q))); // R10
endmodule

// File: rtl/vic_prio.sv
`timescale 1ns/1ps
// Module: vic_prio
// Matches pending normal-line sources against the slot table, picks the
// lowest eligible slot, and tracks nested in-service levels as a bit mask
// (one bit per slot plus one for the default level). Assumes vec_take and
// vec_ack are never high in the same cycle.
module vic_prio
    import vic_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 32,
    parameter int unsigned NUM_SLOT = 16,
    parameter int unsigned VEC_W    = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_pend,
    input  slot_ctl_t          slot_ctl [NUM_SLOT],
    input  logic [VEC_W-1:0]   slot_vec [NUM_SLOT],
    input  logic [VEC_W-1:0]   def_vec,
    input  logic               vec_take,
    input  logic               vec_ack,
    output logic [VEC_W-1:0]   vec_rd_val
);
    localparam int unsigned LVLS    = NUM_SLOT + 1;
    localparam int unsigned DEF_LVL = NUM_SLOT;

    logic [LVLS-1:0]     svc_q, open_lvl, push_lvl, pop_lvl;
    logic [NUM_SLOT-1:0] slot_hit, grant;
    logic [NUM_SRC-1:0]  bound;
    logic                found, use_def, seen;
    logic [VEC_W-1:0]    win_vec;

    // a slot hits when enabled and its bound source is pending on the normal line
    for (genvar g = 0; g < NUM_SLOT; g++) begin : g_hit
        assign slot_hit[g] = slot_ctl[g].en && irq_pend[slot_ctl[g].src];
    end

    // sources claimed by at least one enabled slot
    always_comb begin
        bound = '0;
        for (int i = 0; i < NUM_SLOT; i++) begin
            if (slot_ctl[i].en) bound[slot_ctl[i].src] = 1'b1;
        end
    end

    // a level is open when no level of equal or higher priority is in service
    always_comb begin
        seen = 1'b0;
        for (int i = 0; i < LVLS; i++) begin
            seen        = seen | svc_q[i];
            open_lvl[i] = !seen;
        end
    end

    // lowest-index eligible slot wins; otherwise the default address is shown
    always_comb begin
        grant   = '0;
        found   = 1'b0;
        win_vec = def_vec;
        for (int i = 0; i < NUM_SLOT; i++) begin
            if (!found && slot_hit[i] && open_lvl[i]) begin
                grant[i] = 1'b1;
                found    = 1'b1;
                win_vec  = slot_vec[i];
            end
        end
    end

    assign use_def    = !found && open_lvl[DEF_LVL] && (|(irq_pend & ~bound));
    assign vec_rd_val = win_vec;
    assign push_lvl   = vec_take ? {use_def, grant} : '0;
    assign pop_lvl    = vec_ack ? (svc_q & (~svc_q + LVLS'(1))) : '0;

    // in-service mask: push on vector read, retire the most urgent on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) svc_q <= '0;
        else        svc_q <= (svc_q & ~pop_lvl) | push_lvl;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R6
    AST_NEST_DEEPER: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_take && found && !vec_ack) |=> ($countones(svc_q) == $past($countones(svc_q)) + 1)); // R8
    AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack && !vec_take && (svc_q != '0)) |=> ($countones(svc_q) + 1 == $past($countones(svc_q)))); // R9
endmodule

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
// Module: irq_vector_ctrl (top)
// Vectored interrupt controller: register file plus slot priority logic.
// Assumes NUM_SRC <= 32 and that bus strobes are single-cycle per access.
module irq_vector_ctrl
    import vic_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 32,
    parameter int unsigned NUM_SLOT = 16,
    parameter int unsigned VEC_W    = 32,
    parameter logic [31:0] ID_WORD  = 32'h0053_7A21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic               bus_we,
    input  logic               bus_re,
    input  logic               bus_priv,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] src_req,
    output logic               irq_o,
    output logic               fiq_o
);
    logic [NUM_SRC-1:0] irq_pend, fiq_pend;
    slot_ctl_t          slot_ctl [NUM_SLOT];
    logic [VEC_W-1:0]   slot_vec [NUM_SLOT];
    logic [VEC_W-1:0]   def_vec, vec_rd_val;
    logic               wr_acc, vec_take, vec_ack;

    assign vec_take = bus_re && (bus_addr == OFS_CUR_VEC);
    assign vec_ack  = wr_acc && (bus_addr == OFS_CUR_VEC);

    vic_regs #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .VEC_W(VEC_W), .ID_WORD(ID_WORD)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_priv(bus_priv), .src_req(src_req), .vec_rd_val(vec_rd_val),
        .bus_rdata(bus_rdata), .wr_acc(wr_acc), .irq_pend(irq_pend), .fiq_pend(fiq_pend),
        .slot_ctl(slot_ctl), .slot_vec(slot_vec), .def_vec(def_vec)
    );

    vic_prio #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .VEC_W(VEC_W)) u_prio (
        .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .slot_ctl(slot_ctl),
        .slot_vec(slot_vec), .def_vec(def_vec), .vec_take(vec_take), .vec_ack(vec_ack),
        .vec_rd_val(vec_rd_val)
    );

    // request lines are plain reductions of the masked pending vectors
    assign irq_o = |irq_pend;
    assign fiq_o = |fiq_pend;

    AST_FIQ_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> (bus_rdata != '0 || bus_addr != OFS_FIQ_STAT)); // R4
endmodule

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;
    localparam int NV = 16;
    localparam logic [31:0] IDW = 32'h0053_7A21;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, src = '0;
    logic        bus_we = 1'b0, bus_re = 1'b0, bus_priv = 1'b1;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // reference model state
    logic [31:0] m_en, m_soft, m_sel, m_def;
    logic        m_lock;
    logic [31:0] m_vec [NV];
    logic [5:0]  m_ctl [NV];
    int          svc[$];

    irq_vector_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_priv(bus_priv), .bus_rdata(bus_rdata),
        .src_req(src), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #2.5 clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void m_reset();
        m_en = 0; m_soft = 0; m_sel = 0; m_def = 0; m_lock = 0;
        for (int i = 0; i < NV; i++) begin m_vec[i] = 0; m_ctl[i] = 0; end
        svc.delete();
    endfunction

    function automatic logic [31:0] m_irqp();
        return (src | m_soft) & m_en & ~m_sel;
    endfunction

    function automatic logic [31:0] m_fiqp();
        return (src | m_soft) & m_en & m_sel;
    endfunction

    // best vector per the requirements: returns address and level to push (-1 none)
    function automatic void m_pick(output logic [31:0] val, output int lvl);
        logic [31:0] p, bnd;
        int top;
        p = m_irqp(); bnd = 0; lvl = -1; val = m_def;
        top = (svc.size() == 0) ? 99 : svc[0];
        for (int i = 0; i < NV; i++) if (m_ctl[i][5]) bnd[m_ctl[i][4:0]] = 1'b1;
        for (int i = 0; i < NV; i++)
            if (lvl < 0 && m_ctl[i][5] && p[m_ctl[i][4:0]] && i < top) lvl = i;
        if (lvl >= 0) val = m_vec[lvl];
        else if ((p & ~bnd) != 0 && svc.size() == 0) lvl = NV;
    endfunction

    function automatic logic [31:0] m_read(int a);
        logic [31:0] v; int l;
        if (a == 'h000) return m_irqp();
        if (a == 'h004) return m_fiqp();
        if (a == 'h00C) return m_sel;
        if (a == 'h010) return m_en;
        if (a == 'h018) return m_soft;
        if (a == 'h020) return {31'b0, m_lock};
        if (a == 'h030) begin m_pick(v, l); return v; end
        if (a == 'h034) return m_def;
        if (a >= 'h100 && a < 'h100 + 4*NV) return m_vec[(a - 'h100) / 4];
        if (a >= 'h200 && a < 'h200 + 4*NV) return {26'b0, m_ctl[(a - 'h200) / 4]};
        if (a >= 'hFE0 && a <= 'hFEC) return {24'b0, IDW[8*((a - 'hFE0)/4) +: 8]};
        return 0;
    endfunction

    task automatic wr(int a, logic [31:0] d, logic p = 1'b1);
        @(negedge clk);
        bus_addr = 12'(a); bus_wdata = d; bus_priv = p; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_priv = 1'b1;
        if (p || !m_lock) begin
            if (a == 'h00C) m_sel = d;
            else if (a == 'h010) m_en |= d;
            else if (a == 'h014) m_en &= ~d;
            else if (a == 'h018) m_soft |= d;
            else if (a == 'h01C) m_soft &= ~d;
            else if (a == 'h020) m_lock = d[0];
            else if (a == 'h030) begin if (svc.size() != 0) void'(svc.pop_front()); end
            else if (a == 'h034) m_def = d;
            else if (a >= 'h100 && a < 'h100 + 4*NV) m_vec[(a - 'h100) / 4] = d;
            else if (a >= 'h200 && a < 'h200 + 4*NV) m_ctl[(a - 'h200) / 4] = d[5:0];
        end
    endtask

    task automatic rd(int a, string tag);
        logic [31:0] v; int l;
        @(negedge clk);
        bus_addr = 12'(a); bus_re = 1'b1;
        #1;
        check(tag, bus_rdata, m_read(a));
        m_pick(v, l);
        @(posedge clk); #1;
        bus_re = 1'b0;
        if (a == 'h030 && l >= 0) svc.push_front(l);
    endtask

    task automatic set_src(logic [31:0] v);
        @(negedge clk);
        src = v;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 m_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // every-cycle comparison of the request lines against the model (R4)
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            check("R4 irq_o", {31'b0, irq_o}, {31'b0, |m_irqp()});
            check("R4 fiq_o", {31'b0, fiq_o}, {31'b0, |m_fiqp()});
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_reset();
        do_reset();
        // R1: cleared state after reset
        rd('h010, "R1 enable"); rd('h018, "R1 soft"); rd('h00C, "R1 steer");
        rd('h020, "R1 lock"); rd('h204, "R1 ctl"); rd('h034, "R1 default");
        // R11: identification bytes and unmapped reads
        for (int i = 0; i < 4; i++) rd('hFE0 + 4*i, "R11 id");
        rd('h300, "R11 unmapped");
        // R2: set/clear enable
        wr('h010, 32'h0000_00F0); rd('h010, "R2 set");
        wr('h010, 32'h0000_000F); rd('h010, "R2 set more");
        wr('h014, 32'h0000_0030); rd('h010, "R2 clear");
        wr('h010, 0); wr('h014, 0); rd('h010, "R2 zero writes");
        // R3/R5/R4: soft raise, steering, live status
        set_src(32'h0000_0004); rd('h000, "R5 irq status");
        wr('h018, 32'h0000_0002); rd('h018, "R3 soft"); rd('h000, "R3 status with soft");
        wr('h00C, 32'h0000_0004); rd('h000, "R5 irq after steer"); rd('h004, "R5 fiq status");
        wr('h01C, 32'h0000_0002); rd('h000, "R3 soft cleared");
        set_src(32'h0000_0000); rd('h004, "R5 fiq idle");
        // slot table setup
        wr('h00C, 0); wr('h010, 32'hFFFF_FFFF);
        for (int i = 0; i < NV; i++) wr('h100 + 4*i, 32'h1000 + 32'(i) * 32'h10);
        wr('h208, 32'h27); wr('h214, 32'h23); wr('h224, 32'h34);
        wr('h034, 32'hDEAD_0000);
        rd('h214, "R6 ctl readback"); rd('h108, "R6 vec readback");
        // R6/R8: nesting
        set_src(32'h0010_0008); rd('h030, "R6 slot5 wins");
        set_src(32'h0010_0088); rd('h030, "R8 slot2 preempts");
        rd('h030, "R8 no higher returns default");
        wr('h030, 0); rd('h030, "R9 slot2 again");
        wr('h030, 0); wr('h030, 0);
        set_src(32'h0010_0008); rd('h030, "R6 slot5 after unwind");
        wr('h030, 0);
        // R7: default level
        set_src(32'h0000_0800); rd('h030, "R7 default pushed");
        set_src(32'h0000_0808); rd('h030, "R7 slot above default");
        rd('h030, "R7 nothing eligible");
        wr('h030, 0); wr('h030, 0); wr('h030, 0);
        rd('h030, "R9 empty ack harmless");
        wr('h030, 0);
        // R6: fast-steered and disabled slot sources
        set_src(32'h0000_0008); wr('h00C, 32'h0000_0008); rd('h030, "R6 fiq bypass");
        wr('h00C, 0); wr('h214, 32'h03); rd('h030, "R6 disabled slot");
        wr('h030, 0);
        // R10: lock
        wr('h020, 1); wr('h014, 32'hFFFF_FFFF, 1'b0); rd('h010, "R10 locked enable");
        wr('h020, 0, 1'b0); rd('h020, "R10 lock kept");
        wr('h214, 32'h23); rd('h030, "R10 slot5 pushed");
        wr('h030, 0, 1'b0); rd('h030, "R10 ack ignored");
        wr('h030, 0); rd('h030, "R10 privileged ack");
        wr('h030, 0);
        wr('h020, 0); rd('h020, "R10 unlocked");
        // R1: reset mid-run
        wr('h018, 32'h0000_0100); wr('h00C, 32'h0000_0200); rd('h030, "R1 before reset");
        do_reset();
        rd('h010, "R1 enable again"); rd('h018, "R1 soft again"); rd('h00C, "R1 steer again");
        rd('h214, "R1 slot ctl"); rd('h114, "R1 slot vec"); rd('h030, "R1 vector after reset");
        set_src(0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule